// File: doc/BRIEF.md
# Serial channel interrupt combiner

This block is glue logic between four serial channels, provided by two dual serial controllers, and a CPU. Every channel has two open-drain, active-low request lines: one for its receiver and one for its transmitter. The block brings all eight lines into the system clock domain and drives one registered, active-low interrupt request to the CPU. A ninth request line from the expansion socket also reaches that output.

Software reads a single 8-bit status byte to see which sources want service. The byte sits at one fixed offset inside the 256-byte window of the system-management registers. Receivers fill the low nibble and transmitters fill the high nibble. An interrupt handler can therefore shift the receive flags out first and find the transmit flags waiting in the low nibble. The byte shows the live, synchronised level of the request lines. It is not a history of past requests, so a line that is released drops out of the byte.

Top module: `sio_irq_agg`

## Requirements
- R1: While `rst` is high at a clock edge, `cpu_irq_n` is 1 and `bus_rdata` is 0 after that edge.
- R2: Status bit k (k = 0..3) is 1 exactly when the receive request of channel k (A=0, B=1, C=2, D=3) is low. Status bit 4+k is 1 exactly when the transmit request of channel k is low.
- R3: The status byte follows the current line levels and holds no history. Once a line returns high, its bit reads 0 again after the synchroniser delay.
- R4: `cpu_irq_n` is 0 whenever any status bit is 1 or the expansion request is low. It is 1 otherwise.
- R5: The expansion request drives `cpu_irq_n` but never shows up in any status bit.
- R6: A read at the status offset 0x1C, qualified by `bus_sel`=1, `bus_rw`=1 (read) and `bus_phase`=1, returns the status byte on `bus_rdata` after the next clock edge. In every other cycle `bus_rdata` is 0.
- R7: A write cycle (`bus_rw`=0) at the status offset has no effect. `bus_rdata` stays 0 and a later read returns the unchanged line status.
- R8: Each request level sampled at clock edge n shows up in `cpu_irq_n` and in the status returned by a read qualified at edge n+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_req_n | input | 4 | Receive requests of channels A..D, active low |
| tx_req_n | input | 4 | Transmit requests of channels A..D, active low |
| exp_req_n | input | 1 | Expansion socket request, active low |
| bus_sel | input | 1 | Select for the management register window |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_phase | input | 1 | Bus clock phase; a read is taken while it is high |
| bus_addr | input | 8 | Offset inside the management window |
| bus_rdata | output | 8 | Registered read data |
| cpu_irq_n | output | 1 | Combined interrupt request to the CPU, active low |

## Verification
A status read can be taken at the same clock edge at which a newly sampled request reaches the synchronised status. The CPU interrupt output also switches at that edge. The bench provokes this by holding a qualified read on the bus across a request transition. It then samples `bus_rdata` and `cpu_irq_n` after each following edge. A behavioural queue model of the sampled line levels judges the result: the read must return the level from two edges earlier, and the interrupt output must switch at that same edge and not a cycle sooner.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  // classification of one bus cycle as seen by the read port
  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_WRITE   = 2'd1,
    ACC_RD_STAT = 2'd2,
    ACC_RD_MISS = 2'd3
  } acc_kind_t;

  localparam int unsigned DEF_CH_COUNT = 4;
  localparam int unsigned DEF_SYNC_LEN = 2;
  localparam int unsigned DEF_ADDR_W   = 8;
  localparam logic [7:0]  DEF_STAT_OFS = 8'h1C;
endpackage

// File: rtl/sio_sync_bank.sv
module sio_sync_bank #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // shift chain of STAGES registers per bit; reset to the idle (released) level
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sio_irq_combine.sv
module sio_irq_combine #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned STAT_W = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_lvl_n,
  input  logic [NUM_CH-1:0] tx_lvl_n,
  input  logic              exp_lvl_n,
  output logic [STAT_W-1:0] status,
  output logic              cpu_irq_n
);
  // receivers in the low half, transmitters in the high half, channel A lowest
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign status[c]          = ~rx_lvl_n[c];
    assign status[NUM_CH + c] = ~tx_lvl_n[c];
  end

  logic any_req;
  assign any_req = (|status) | ~exp_lvl_n;

  always_ff @(posedge clk) begin
    if (rst) cpu_irq_n <= 1'b1;
    else     cpu_irq_n <= ~any_req;
  end
endmodule

// File: rtl/sio_bus_port.sv
module sio_bus_port
  import sio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_rw,
  input  logic              bus_phase,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] bus_rdata
);
  acc_kind_t acc;

  always_comb begin
    if (!bus_sel || !bus_phase)   acc = ACC_IDLE;
    else if (!bus_rw)             acc = ACC_WRITE;
    else if (bus_addr == STAT_ADDR) acc = ACC_RD_STAT;
    else                          acc = ACC_RD_MISS;
  end

  // read-only register: write cycles fall through to the zero default
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (acc)
        ACC_RD_STAT: bus_rdata <= status;
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_irq_agg.sv
module sio_irq_agg
  import sio_irq_pkg::*;
#(
  parameter int unsigned NUM_CH    = DEF_CH_COUNT,
  parameter int unsigned SYNC_LEN  = DEF_SYNC_LEN,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DEF_STAT_OFS),
  localparam int unsigned STAT_W   = 2 * NUM_CH,
  localparam int unsigned IN_W     = STAT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_req_n,
  input  logic [NUM_CH-1:0] tx_req_n,
  input  logic              exp_req_n,
  input  logic              bus_sel,
  input  logic              bus_rw,
  input  logic              bus_phase,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [STAT_W-1:0] bus_rdata,
  output logic              cpu_irq_n
);
  logic [IN_W-1:0]   raw_n;
  logic [IN_W-1:0]   sync_n;
  logic [NUM_CH-1:0] rx_sync_n;
  logic [NUM_CH-1:0] tx_sync_n;
  logic              exp_sync_n;
  logic [STAT_W-1:0] status_w;

  assign raw_n = {exp_req_n, tx_req_n, rx_req_n};

  sio_sync_bank #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_LEN),
    .RST_VAL({IN_W{1'b1}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_n),
    .q   (sync_n)
  );

  assign rx_sync_n  = sync_n[NUM_CH-1:0];
  assign tx_sync_n  = sync_n[STAT_W-1:NUM_CH];
  assign exp_sync_n = sync_n[IN_W-1];

  sio_irq_combine #(
    .NUM_CH (NUM_CH)
  ) u_comb (
    .clk       (clk),
    .rst       (rst),
    .rx_lvl_n  (rx_sync_n),
    .tx_lvl_n  (tx_sync_n),
    .exp_lvl_n (exp_sync_n),
    .status    (status_w),
    .cpu_irq_n (cpu_irq_n)
  );

  sio_bus_port #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (STAT_W),
    .STAT_ADDR (STAT_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_rw    (bus_rw),
    .bus_phase (bus_phase),
    .bus_addr  (bus_addr),
    .status    (status_w),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/sio_irq_agg_chk.sv
module sio_irq_agg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAT_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_rw,
  input logic              bus_phase,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [STAT_W-1:0] status,
  input logic              exp_sync_n,
  input logic [STAT_W-1:0] bus_rdata,
  input logic              cpu_irq_n
);
  logic rd_hit;
  assign rd_hit = bus_sel && bus_rw && bus_phase && (bus_addr == STAT_ADDR);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (cpu_irq_n && bus_rdata == '0));

  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    ((status != '0) || !exp_sync_n) |=> !cpu_irq_n);

  p_irq_clear_r4: assert property (@(posedge clk) disable iff (rst)
    ((status == '0) && exp_sync_n) |=> cpu_irq_n);

  p_read_value_r6: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (bus_rdata == $past(status)));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (bus_rdata == '0));

  p_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_rw) |=> (bus_rdata == '0));
endmodule

bind sio_irq_agg sio_irq_agg_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_W    (STAT_W),
  .STAT_ADDR (STAT_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_rw     (bus_rw),
  .bus_phase  (bus_phase),
  .bus_addr   (bus_addr),
  .status     (status_w),
  .exp_sync_n (exp_sync_n),
  .bus_rdata  (bus_rdata),
  .cpu_irq_n  (cpu_irq_n)
);

// File: tb/sio_irq_agg_tb.sv
module sio_irq_agg_tb;
  localparam int N = 4;
  localparam logic [7:0] OFS = 8'h1C;
  localparam logic [2*N:0] IDLE = '1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [N-1:0] rx_n = '1;
  logic [N-1:0] tx_n = '1;
  logic exp_n = 1'b1;
  logic sel = 1'b0, rw = 1'b1, phase = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] rdata;
  logic irq_n;

  sio_irq_agg u_dut (
    .clk(clk), .rst(rst), .rx_req_n(rx_n), .tx_req_n(tx_n), .exp_req_n(exp_n),
    .bus_sel(sel), .bus_rw(rw), .bus_phase(phase), .bus_addr(addr),
    .bus_rdata(rdata), .cpu_irq_n(irq_n)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of line samples, newest first
  logic [2*N:0] hist[$];
  logic exp_irq_n;
  logic [7:0] exp_rdata;
  bit started = 0;

  function automatic logic [7:0] stat_of(input logic [2*N:0] s);
    logic [7:0] v;
    for (int k = 0; k < N; k++) begin
      v[k]     = (s[k] == 1'b0);
      v[N + k] = (s[N + k] == 1'b0);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    logic [2*N:0] old;
    started = 1;
    if (rst) begin
      hist = '{IDLE, IDLE};
      exp_irq_n = 1'b1;
      exp_rdata = 8'h00;
    end else begin
      old = hist[1];
      exp_irq_n = !((stat_of(old) != 8'h00) || (old[2*N] == 1'b0));
      exp_rdata = (sel && rw && phase && addr == OFS) ? stat_of(old) : 8'h00;
      hist.push_front({exp_n, tx_n, rx_n});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(irq_n == exp_irq_n, "R4 model irq", {7'd0, irq_n}, {7'd0, exp_irq_n});
      chk(rdata == exp_rdata, "R6 model rdata", rdata, exp_rdata);
    end
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic read_stat(output logic [7:0] v);
    @(negedge clk);
    sel = 1; rw = 1; phase = 1; addr = OFS;
    @(negedge clk);
    v = rdata;
    sel = 0; phase = 0; addr = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq in reset", {7'd0, irq_n}, 8'h01);
    chk(rdata == 8'h00, "R1 rdata in reset", rdata, 8'h00);
    rst = 0;
    settle();

    read_stat(v);
    chk(v == 8'h00, "R4 idle status", v, 8'h00);
    chk(irq_n == 1'b1, "R4 idle irq", {7'd0, irq_n}, 8'h01);

    for (int c = 0; c < N; c++) begin
      rx_n = '1; rx_n[c] = 1'b0;
      settle();
      read_stat(v);
      chk(v == 8'(1 << c), "R2 receive bit", v, 8'(1 << c));
      chk(irq_n == 1'b0, "R4 receive irq", {7'd0, irq_n}, 8'h00);
    end
    rx_n = '1;
    for (int c = 0; c < N; c++) begin
      tx_n = '1; tx_n[c] = 1'b0;
      settle();
      read_stat(v);
      chk(v == 8'(1 << (N + c)), "R2 transmit bit", v, 8'(1 << (N + c)));
    end

    rx_n = 4'b1010; tx_n = 4'b0101;
    settle();
    read_stat(v);
    chk(v == 8'hA5, "R2 mixed pattern", v, 8'hA5);

    rx_n = '1; tx_n = '1;
    settle();
    read_stat(v);
    chk(v == 8'h00, "R3 released lines", v, 8'h00);
    chk(irq_n == 1'b1, "R3 irq released", {7'd0, irq_n}, 8'h01);

    exp_n = 0;
    settle();
    chk(irq_n == 1'b0, "R5 expansion irq", {7'd0, irq_n}, 8'h00);
    read_stat(v);
    chk(v == 8'h00, "R5 expansion hidden", v, 8'h00);
    exp_n = 1;

    rx_n[0] = 1'b0;
    settle();
    @(negedge clk);
    sel = 1; rw = 0; phase = 1; addr = OFS;
    @(negedge clk);
    chk(rdata == 8'h00, "R7 write cycle data", rdata, 8'h00);
    sel = 0; rw = 1; phase = 0;
    read_stat(v);
    chk(v == 8'h01, "R7 status after write", v, 8'h01);

    @(negedge clk);
    sel = 1; rw = 1; phase = 1; addr = 8'h1D;
    @(negedge clk);
    chk(rdata == 8'h00, "R6 other offset", rdata, 8'h00);
    addr = OFS; phase = 0;
    @(negedge clk);
    chk(rdata == 8'h00, "R6 phase low", rdata, 8'h00);
    sel = 0; phase = 1;
    @(negedge clk);
    chk(rdata == 8'h00, "R6 not selected", rdata, 8'h00);
    phase = 0;
    rx_n = '1;
    settle();

    // read held across a transition: value and irq switch at the same edge
    sel = 1; rw = 1; phase = 1; addr = OFS;
    @(negedge clk);
    tx_n[3] = 1'b0;
    @(negedge clk);
    chk(irq_n == 1'b1, "R8 edge1 irq", {7'd0, irq_n}, 8'h01);
    chk(rdata == 8'h00, "R8 edge1 data", rdata, 8'h00);
    @(negedge clk);
    chk(irq_n == 1'b1, "R8 edge2 irq", {7'd0, irq_n}, 8'h01);
    chk(rdata == 8'h00, "R8 edge2 data", rdata, 8'h00);
    @(negedge clk);
    chk(irq_n == 1'b0, "R8 edge3 irq", {7'd0, irq_n}, 8'h00);
    chk(rdata == 8'h80, "R8 edge3 data", rdata, 8'h80);
    sel = 0; phase = 0;
    tx_n = '1;
    settle();

    rst = 1;
    tx_n[0] = 1'b0;
    @(negedge clk);
    chk(irq_n == 1'b1, "R1 irq reset again", {7'd0, irq_n}, 8'h01);
    rst = 0;
    tx_n = '1;
    settle();

    finish_run();
  end
endmodule